// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic stage of a small accumulator-oriented processor. It combines an 8-bit accumulator operand and an 8-bit second operand under a 4-bit operation code and produces an 8-bit result with no clock delay. Beside the result it keeps five status flags in flip-flops: sign, zero, auxiliary carry, parity and carry. The stored carry feeds back into the add-with-carry, subtract-with-borrow and rotate-through-carry operations.

Each operation has a fixed rule for which flags it may change. The flags are written only on a clock edge where the update enable is high. A separate load path writes the whole flag byte at once, which lets the surrounding core save the flags and the accumulator as one 16-bit status word and restore them later. All pins are plain control and status signals. The operands go in and the result comes out with no handshake, because the result is ready in the same cycle. Nothing here can back-pressure or stall the caller.

Top module: `alu8_status`

## Requirements
- R1: After reset `flag_byte` reads 0x00. The flag byte layout is sign at bit 7, zero at bit 6, auxiliary carry at bit 4, parity at bit 2 and carry at bit 0; bits 5, 3 and 1 always read 0.
- R2: Add (code 0) returns `op_a+op_b` and add-with-carry (code 1) returns `op_a+op_b+carry`, both modulo 256. Carry is set to the carry out of bit 7, and auxiliary carry to the carry out of bit 3.
- R3: Subtract (code 2) computes `op_a-op_b` and subtract-with-borrow (code 3) computes `op_a-op_b-carry`, modulo 256. Carry becomes 1 on a borrow out of bit 7. Auxiliary carry becomes 1 on a borrow from the low nibble, meaning the low nibble of `op_a` is less than the low nibble of `op_b` plus the borrow-in. Compare (code 12) sets the flags as subtract does, but `result` equals `op_a`.
- R4: Every operation that updates sign, zero and parity derives them from its 8-bit result: sign is bit 7, zero is 1 when the result is 0x00, and parity is 1 when the result has an even number of ones. For compare, these flags come from the discarded difference.
- R5: AND (4), OR (5) and XOR (6) set sign, zero and parity and clear both carry and auxiliary carry.
- R6: Increment (8) and decrement (9) return `op_a+1` and `op_a-1`, modulo 256. They update sign, zero, parity and auxiliary carry (a carry out of bit 3 for increment, a borrow into the low nibble for decrement) and leave carry unchanged.
- R7: Rotate left circular (10) moves each bit up one place, copies bit 7 into bit 0 and into carry, and changes no other flag.
- R8: Rotate right through carry (11) moves each bit down one place, loads the old carry into bit 7 and bit 0 into carry, and changes no other flag.
- R9: Complement (7) returns the bitwise inverse of `op_a` and changes no flag. Complement carry (13) inverts only carry and returns `op_a`.
- R10: Flags change only on a rising clock edge with `flag_we` high. With `flag_we` low they hold whatever operation is applied. Codes 14 and 15 return `op_a` and change no flag.
- R11: With `flag_load` high, the next edge loads the flags from `flag_wdata` in the R1 layout and ignores the unused bits. This load takes priority over `flag_we`. `status_word` is `{op_a, flag_byte}`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_a | input | 8 | Accumulator operand |
| op_b | input | 8 | Second operand |
| op_sel | input | 4 | Operation code |
| flag_we | input | 1 | Store this cycle's flag changes on the next edge |
| flag_load | input | 1 | Load the whole flag byte from `flag_wdata` |
| flag_wdata | input | 8 | Flag byte to load |
| result | output | 8 | Combinational result |
| flag_byte | output | 8 | Stored flags in packed layout |
| status_word | output | 16 | Accumulator operand above flag byte |

## Verification
A corrupt stored flag shows on `flag_byte` in the cycle after the edge that wrote it. A corrupt carry also shows on `result` as soon as an add-with-carry, subtract-with-borrow or right rotate uses it. A wrong update mask, such as increment touching carry or a rotate touching zero, shows only after the flag is read back. For that reason every step compares the full flag byte, not just the flag that the operation is meant to change.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DATA_W = 8;
  localparam int OP_W   = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_SBB = 4'd3,
    OP_AND = 4'd4,  OP_OR  = 4'd5,  OP_XOR = 4'd6,  OP_CMA = 4'd7,
    OP_INC = 4'd8,  OP_DEC = 4'd9,  OP_RLC = 4'd10, OP_RAR = 4'd11,
    OP_CMP = 4'd12, OP_CMC = 4'd13, OP_NP0 = 4'd14, OP_NP1 = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } alu_flags_t;

  localparam int NFLAGS = $bits(alu_flags_t);
endpackage

// File: rtl/alu8_datapath.sv
module alu8_datapath
  import alu8_pkg::*;
#(
  parameter int WIDTH = DATA_W
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  alu_op_e          op,
  input  logic             cy_in,
  output logic [WIDTH-1:0] res,
  output alu_flags_t       nf,
  output alu_flags_t       mask
);
  localparam int HALF = WIDTH / 2;

  logic [WIDTH-1:0] b_eff;
  logic             cin;
  logic             sub;
  logic [WIDTH:0]   sum;
  logic [HALF:0]    low;
  logic             cy_ar, ac_ar;

  always_comb begin
    b_eff = b;
    cin   = 1'b0;
    sub   = 1'b0;
    unique case (op)
      OP_ADC:         cin = cy_in;
      OP_SUB, OP_CMP: begin sub = 1'b1; b_eff = ~b; cin = 1'b1; end
      OP_SBB:         begin sub = 1'b1; b_eff = ~b; cin = ~cy_in; end
      OP_INC:         b_eff = WIDTH'(1);
      OP_DEC:         begin sub = 1'b1; b_eff = ~WIDTH'(1); cin = 1'b1; end
      default:        ;
    endcase
  end

  assign sum   = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, cin};
  assign low   = {1'b0, a[HALF-1:0]} + {1'b0, b_eff[HALF-1:0]} + {{HALF{1'b0}}, cin};
  assign cy_ar = sub ? ~sum[WIDTH] : sum[WIDTH];
  assign ac_ar = sub ? ~low[HALF]  : low[HALF];

  logic [WIDTH-1:0] szp_src;

  always_comb begin
    res     = a;
    nf      = '0;
    mask    = '0;
    szp_src = sum[WIDTH-1:0];
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
        res = sum[WIDTH-1:0]; mask = '1; nf.cy = cy_ar; nf.ac = ac_ar;
      end
      OP_CMP: begin
        mask = '1; nf.cy = cy_ar; nf.ac = ac_ar;
      end
      OP_AND, OP_OR, OP_XOR: begin
        if (op == OP_AND)     res = a & b;
        else if (op == OP_OR) res = a | b;
        else                  res = a ^ b;
        szp_src = res;
        mask = '1;
      end
      OP_CMA: res = ~a;
      OP_INC, OP_DEC: begin
        res = sum[WIDTH-1:0];
        mask = '1; mask.cy = 1'b0; nf.ac = ac_ar;
      end
      OP_RLC: begin
        res = {a[WIDTH-2:0], a[WIDTH-1]}; mask.cy = 1'b1; nf.cy = a[WIDTH-1];
      end
      OP_RAR: begin
        res = {cy_in, a[WIDTH-1:1]}; mask.cy = 1'b1; nf.cy = a[0];
      end
      OP_CMC: begin
        mask.cy = 1'b1; nf.cy = ~cy_in;
      end
      default: ;
    endcase
    nf.s = szp_src[WIDTH-1];
    nf.z = (szp_src == '0);
    nf.p = ~(^szp_src);
  end
endmodule

// File: rtl/alu8_flag_store.sv
module alu8_flag_store
  import alu8_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic       load,
  input  alu_flags_t ld_val,
  input  alu_flags_t nf,
  input  alu_flags_t mask,
  output alu_flags_t q
);
  logic [NFLAGS-1:0] q_bits;

  for (genvar i = 0; i < NFLAGS; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  q_bits[i] <= 1'b0;
      else if (load)               q_bits[i] <= ld_val[i];
      else if (we && mask[i])      q_bits[i] <= nf[i];
    end
  end

  assign q = alu_flags_t'(q_bits);

  // R10
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!we && !load) |=> (q == $past(q)));

  // R11
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q == $past(ld_val)));
endmodule

// File: rtl/alu8_status.sv
module alu8_status
  import alu8_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  op_a,
  input  logic [7:0]  op_b,
  input  logic [3:0]  op_sel,
  input  logic        flag_we,
  input  logic        flag_load,
  input  logic [7:0]  flag_wdata,
  output logic [7:0]  result,
  output logic [7:0]  flag_byte,
  output logic [15:0] status_word
);
  alu_flags_t flags_q, nf, mask, ld_val;
  alu_op_e    op;

  assign op = alu_op_e'(op_sel);

  alu8_datapath #(.WIDTH(DATA_W)) u_dp (
    .a    (op_a),
    .b    (op_b),
    .op   (op),
    .cy_in(flags_q.cy),
    .res  (result),
    .nf   (nf),
    .mask (mask)
  );

  assign ld_val = '{s: flag_wdata[7], z: flag_wdata[6], ac: flag_wdata[4],
                    p: flag_wdata[2], cy: flag_wdata[0]};

  alu8_flag_store u_fs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (flag_we),
    .load  (flag_load),
    .ld_val(ld_val),
    .nf    (nf),
    .mask  (mask),
    .q     (flags_q)
  );

  assign flag_byte   = {flags_q.s, flags_q.z, 1'b0, flags_q.ac, 1'b0, flags_q.p, 1'b0, flags_q.cy};
  assign status_word = {op_a, flag_byte};

  // R6
  incdec_keeps_cy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && !flag_load && (op_sel == 4'd8 || op_sel == 4'd9)) |=> $stable(flag_byte[0]));

  // R7
  rotate_only_cy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && !flag_load && (op_sel == 4'd10 || op_sel == 4'd11)) |=> $stable(flag_byte[7:1]));

  // R5
  logic_clears_cy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && !flag_load && (op_sel >= 4'd4) && (op_sel <= 4'd6)) |=> (flag_byte[0] == 1'b0 && flag_byte[4] == 1'b0));

  // R9
  cma_no_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && !flag_load && op_sel == 4'd7) |=> $stable(flag_byte));

  // R1
  unused_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_byte[5] == 1'b0 && flag_byte[3] == 1'b0 && flag_byte[1] == 1'b0));
endmodule

// File: tb/tb_alu8_status.sv
module tb_alu8_status;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  op_a = '0, op_b = '0;
  logic [3:0]  op_sel = '0;
  logic        flag_we = 1'b0, flag_load = 1'b0;
  logic [7:0]  flag_wdata = '0;
  logic [7:0]  result, flag_byte;
  logic [15:0] status_word;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_fb = 8'h00;

  always #5 clk = ~clk;

  alu8_status dut (.*);

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic par_even(input logic [7:0] v);
    return ~(^v);
  endfunction

  // returns {result, new flag byte}
  function automatic logic [15:0] model(input logic [3:0] op, input logic [7:0] a, b,
                                        input logic [7:0] fb);
    logic cy, s, z, ac, p, c2;
    logic [8:0] w;
    logic [7:0] r, szp;
    logic do_szp;
    cy = fb[0]; s = fb[7]; z = fb[6]; ac = fb[4]; p = fb[2];
    r = a; do_szp = 0; szp = 8'h00;
    case (op)
      0, 1: begin
        c2 = (op == 1) ? cy : 1'b0;
        w = a + b + c2; r = w[7:0]; cy = w[8];
        ac = ((a & 8'h0F) + (b & 8'h0F) + c2) > 15;
        szp = r; do_szp = 1;
      end
      2, 3, 12: begin
        c2 = (op == 3) ? cy : 1'b0;
        w = {1'b0, a} - {1'b0, b} - c2;
        cy = w[8];
        ac = (a & 8'h0F) < ((b & 8'h0F) + c2);
        szp = w[7:0]; do_szp = 1;
        r = (op == 12) ? a : w[7:0];
      end
      4, 5, 6: begin
        r = (op == 4) ? (a & b) : (op == 5) ? (a | b) : (a ^ b);
        cy = 0; ac = 0; szp = r; do_szp = 1;
      end
      7: r = ~a;
      8: begin r = a + 8'd1; ac = (a[3:0] == 4'hF); szp = r; do_szp = 1; end
      9: begin r = a - 8'd1; ac = (a[3:0] == 4'h0); szp = r; do_szp = 1; end
      10: begin r = {a[6:0], a[7]}; cy = a[7]; end
      11: begin r = {cy, a[7:1]}; cy = a[0]; end
      13: cy = ~cy;
      default: ;
    endcase
    if (do_szp) begin s = szp[7]; z = (szp == 0); p = par_even(szp); end
    return {r, s, z, 1'b0, ac, 1'b0, p, 1'b0, cy};
  endfunction

  function automatic string tag(input logic [3:0] op);
    case (op)
      0, 1: return "R2";
      2, 3, 12: return "R3";
      4, 5, 6: return "R5";
      8, 9: return "R6";
      10: return "R7";
      11: return "R8";
      7, 13: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string rq, input string what, input logic [15:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] op, input logic [7:0] a, b, input logic we);
    logic [15:0] m;
    @(negedge clk);
    op_sel = op; op_a = a; op_b = b; flag_we = we; flag_load = 0;
    #1;
    m = model(op, a, b, exp_fb);
    chk(tag(op), "result", {8'h00, result}, {8'h00, m[15:8]});
    chk("R11", "status_word", status_word, {a, exp_fb});
    @(posedge clk);
    if (we) exp_fb = m[7:0];
    #1;
    chk(we ? tag(op) : "R10", "flags", {8'h00, flag_byte}, {8'h00, exp_fb});
  endtask

  task automatic load_flags(input logic [7:0] v, input logic we);
    @(negedge clk);
    flag_load = 1; flag_wdata = v; flag_we = we; op_sel = 4'd13;
    @(posedge clk);
    exp_fb = v & 8'b1101_0101;
    #1;
    chk("R11", "load", {8'h00, flag_byte}, {8'h00, exp_fb});
    flag_load = 0;
  endtask

  initial begin
    void'($urandom(1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "reset flags", {8'h00, flag_byte}, 16'h0000);
    @(negedge clk) rst_n = 1;

    step(0, 8'h0F, 8'h01, 1);   // R2 aux carry
    step(0, 8'hFF, 8'h01, 1);   // R2 carry + zero, R4
    step(1, 8'h10, 8'h20, 1);   // R2 adc with carry=1
    step(2, 8'h00, 8'h01, 1);   // R3 borrow
    step(3, 8'h05, 8'h05, 1);   // R3 sbb with borrow in
    step(12, 8'h42, 8'h42, 1);  // R3 compare equal
    step(12, 8'h10, 8'h20, 1);  // R3 compare less
    step(4, 8'hF0, 8'h3C, 1);   // R5
    step(8, 8'hFF, 8'h00, 1);   // R6 inc keeps carry
    step(9, 8'h00, 8'h00, 1);   // R6 dec borrow
    step(10, 8'h80, 8'h00, 1);  // R7
    step(11, 8'h01, 8'h00, 1);  // R8
    step(11, 8'h00, 8'h00, 1);  // R8 carry into bit 7
    step(7, 8'h5A, 8'h00, 1);   // R9 cma
    step(13, 8'h33, 8'h00, 1);  // R9 cmc
    step(14, 8'h77, 8'h00, 1);  // R10 no-op codes
    step(15, 8'h00, 8'h00, 1);  // R10
    step(0, 8'hFF, 8'hFF, 0);   // R10 we low
    load_flags(8'hFF, 1);       // R11 load over we
    load_flags(8'h2A, 0);       // R11 unused bits ignored

    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 40) == 0)
        load_flags(8'($urandom), 1'($urandom));
      else
        step(4'($urandom), 8'($urandom), 8'($urandom), ($urandom % 5) != 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule